// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Interrupt Routing

This block watches a running clock-and-calendar and raises interrupts when the time reaches one of two programmed alarm points. On every one-second tick it compares the current BCD seconds, minutes, hours and day-or-date with the two alarm register sets. Each alarm field carries a mask bit. A field with its mask set is ignored, so one alarm setting can fire every second, every minute, hourly, daily, or on a chosen day or date. A match sets a sticky flag. Software can clear a flag only by writing zero to it.

The flags are gated by per-alarm enables and drive two active-low outputs. A control bit selects one of two routings. In the first, the first output carries both alarms and the second output carries a square wave at one of four rates taken from the divider taps. In the second, each alarm has its own output. The block also holds an oscillator-stop flag that follows the same write-zero-only rule, and it stores an oscillator-disable control bit. The calendar counter, the oscillator and the serial bus sit outside this block.

Writes use a single strobe with an address. The register offsets are: 0 to 3 for the first alarm's seconds, minutes, hours and day/date; 4 to 6 for the second alarm's minutes, hours and day/date; 7 for control; and 8 for status. Writes to any other offset have no effect.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, all alarm registers are 0 and both alarm flags are 0. The oscillator-stop flag is 1, and the control register holds disable=0, rate=11, split=0 and both enables 0. So after reset `int_a_n`=1 and `sqw_int_b_n` follows `div_taps[3]`.
- R2: First alarm: bit 7 of each of its four registers masks that field. Bits 6:0 of the seconds, minutes and hours registers are compared with the current fields. A flag is set only when every unmasked field matches. With all masks set, it fires on every tick.
- R3: The second alarm has no seconds register, and it fires only on a tick where the current seconds equal 0. It also needs every unmasked minutes, hours and day/date field to match.
- R4: In each day/date register, bit 6 selects what bits 5:0 are compared against. When bit 6 is 0, they are compared with the day of the month (`cur_mday`). When bit 6 is 1, they are compared with the day of the week (`cur_wday`).
- R5: Status offset 8 holds the flags: bit 0 is the first alarm flag and bit 1 is the second alarm flag. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. If a match and a clearing write arrive in the same cycle, the flag ends up set.
- R6: Status bit 7 is the oscillator-stop flag. It is set in the cycle after `osc_fail` is high, and it is cleared only by writing 0 to that bit.
- R7: Control offset 7 uses these bits: bit 7 is oscillator disable (visible on `osc_off`), bits 4:3 select the rate, bit 2 is split, bit 1 is the second alarm enable, and bit 0 is the first alarm enable. With split=1, `int_a_n` is low exactly when the first flag and its enable are both 1. In the same mode, `sqw_int_b_n` is low exactly when the second flag and its enable are both 1.
- R8: With split=0, `int_a_n` is low when either alarm has its flag and its enable both at 1, and `sqw_int_b_n` carries the selected square wave.
- R9: The rate select picks `div_taps[rate]`, where 00 selects the 1 Hz tap, 01 the 4.096 kHz tap, 10 the 8.192 kHz tap and 11 the 32.768 kHz tap.
- R10: A match is sampled only in a cycle where `tick_1s` is high. If the time fields match while the tick is low, no flag is set.
- R11: A write to any offset above 8 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse marking the once-per-second time update |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours with 12/24 and AM/PM bits |
| cur_wday | input | 6 | Current day of week |
| cur_mday | input | 6 | Current day of month, BCD |
| div_taps | input | 4 | Divider outputs indexed by rate code |
| osc_fail | input | 1 | High while the oscillator is stopped |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| int_a_n | output | 1 | Active-low interrupt, first pin |
| sqw_int_b_n | output | 1 | Square wave or active-low second-alarm interrupt |
| alarm_flags | output | 2 | Sticky alarm flags {second, first} |
| osc_stop_flag | output | 1 | Sticky oscillator-stop flag |
| osc_off | output | 1 | Stored oscillator-disable control bit |

## Verification
The alarm comparison is driven with random time fields. Some are copied from the first alarm's registers, some from the second alarm's registers with zero seconds, and the rest are unrelated. This separates "all unmasked fields match" from "a single field differs", and it separates the implicit zero-seconds rule of the second alarm from the first alarm's behaviour. Directed sequences cover the following cases:
- day/date selection with the date and the weekday deliberately disagreeing;
- matching fields held without a tick;
- a clearing write in the same cycle as a match;
- write-one attempts on the flags;
- each rate code with varying tap patterns under both routings.

Random control and status writes, including writes to out-of-range offsets, check that routing and sticky-flag behaviour agree under every mix of enables.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int NUM_ALRM  = 2;
    localparam int RATE_W    = 2;
    localparam int NUM_RATES = 1 << RATE_W;

    typedef enum logic [ADDR_W-1:0] {
        OFS_A1_SEC = 4'd0,
        OFS_A1_MIN = 4'd1,
        OFS_A1_HR  = 4'd2,
        OFS_A1_DAY = 4'd3,
        OFS_A2_MIN = 4'd4,
        OFS_A2_HR  = 4'd5,
        OFS_A2_DAY = 4'd6,
        OFS_CTRL   = 4'd7,
        OFS_STAT   = 4'd8
    } reg_ofs_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] day;
    } alarm_t;

    typedef struct packed {
        logic              osc_off;
        logic [RATE_W-1:0] rate;
        logic              split;
        logic              a2_en;
        logic              a1_en;
    } ctrl_t;

    typedef struct packed {
        alarm_t                a1;
        alarm_t                a2;
        ctrl_t                 ctrl;
        logic                  osf;
        logic [NUM_ALRM-1:0]   flg;
    } state_t;

    localparam ctrl_t CTRL_RST = '{osc_off: 1'b0, rate: '1, split: 1'b0,
                                   a2_en: 1'b0, a1_en: 1'b0};

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  alarm_t     cfg,
    input  logic [6:0] t_sec,
    input  logic [6:0] t_min,
    input  logic [6:0] t_hour,
    input  logic [5:0] t_wday,
    input  logic [5:0] t_mday,
    output logic       hit
);
    logic [5:0] day_ref;
    logic [3:0] fld_ok;

    always_comb begin
        // bit 6 of the day register chooses weekday versus month day
        day_ref   = cfg.day[6] ? t_wday : t_mday;
        fld_ok[0] = cfg.sec[7]  | (cfg.sec[6:0]  == t_sec);
        fld_ok[1] = cfg.min[7]  | (cfg.min[6:0]  == t_min);
        fld_ok[2] = cfg.hour[7] | (cfg.hour[6:0] == t_hour);
        fld_ok[3] = cfg.day[7]  | (cfg.day[5:0]  == day_ref);
        hit       = &fld_ok;
    end
endmodule

// File: rtl/rtc_sqw_sel.sv
module rtc_sqw_sel #(
    parameter  int NUM_RATES = 4,
    localparam int SEL_W     = $clog2(NUM_RATES)
) (
    input  logic [NUM_RATES-1:0] taps,
    input  logic [SEL_W-1:0]     sel,
    output logic                 wave
);
    always_comb begin
        wave = taps[sel];
    end
endmodule

// File: rtl/rtc_irq_route.sv
module rtc_irq_route (
    input  logic [1:0] flg,
    input  logic [1:0] en,
    input  logic       split,
    input  logic       wave,
    output logic       int_a_n,
    output logic       int_b_n
);
    logic [1:0] active;

    always_comb begin
        active  = flg & en;
        int_a_n = ~(active[0] | (active[1] & ~split));
        int_b_n = split ? ~active[1] : wave;
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_1s,
    input  logic [6:0]           cur_sec,
    input  logic [6:0]           cur_min,
    input  logic [6:0]           cur_hour,
    input  logic [5:0]           cur_wday,
    input  logic [5:0]           cur_mday,
    input  logic [NUM_RATES-1:0] div_taps,
    input  logic                 osc_fail,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic                 int_a_n,
    output logic                 sqw_int_b_n,
    output logic [NUM_ALRM-1:0]  alarm_flags,
    output logic                 osc_stop_flag,
    output logic                 osc_off
);
    state_t               st_d, st_q;
    alarm_t               al_cfg [NUM_ALRM];
    logic [NUM_ALRM-1:0]  hit;
    logic [NUM_ALRM-1:0]  keep;
    logic                 osf_keep;
    logic                 wave;
    logic [4:0]           ctrl_lo;

    assign al_cfg[0] = st_q.a1;
    // second alarm seconds register is never written: value 00 with mask 0
    assign al_cfg[1] = st_q.a2;

    for (genvar i = 0; i < NUM_ALRM; i++) begin : g_cmp
        rtc_alarm_cmp u_cmp (
            .cfg    (al_cfg[i]),
            .t_sec  (cur_sec),
            .t_min  (cur_min),
            .t_hour (cur_hour),
            .t_wday (cur_wday),
            .t_mday (cur_mday),
            .hit    (hit[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        keep     = '1;
        osf_keep = 1'b1;
        if (reg_we) begin
            case (reg_ofs_e'(reg_addr))
                OFS_A1_SEC: st_d.a1.sec  = reg_wdata;
                OFS_A1_MIN: st_d.a1.min  = reg_wdata;
                OFS_A1_HR:  st_d.a1.hour = reg_wdata;
                OFS_A1_DAY: st_d.a1.day  = reg_wdata;
                OFS_A2_MIN: st_d.a2.min  = reg_wdata;
                OFS_A2_HR:  st_d.a2.hour = reg_wdata;
                OFS_A2_DAY: st_d.a2.day  = reg_wdata;
                OFS_CTRL: st_d.ctrl = '{osc_off: reg_wdata[7],
                                        rate:    reg_wdata[4:3],
                                        split:   reg_wdata[2],
                                        a2_en:   reg_wdata[1],
                                        a1_en:   reg_wdata[0]};
                OFS_STAT: begin
                    keep     = reg_wdata[NUM_ALRM-1:0];
                    osf_keep = reg_wdata[7];
                end
                default: ;
            endcase
        end
        // a match in the same cycle wins over a clearing write
        st_d.flg = (st_q.flg & keep) | (tick_1s ? hit : '0);
        st_d.osf = (st_q.osf & osf_keep) | osc_fail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_RST;
            st_q.osf  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    rtc_sqw_sel #(.NUM_RATES(NUM_RATES)) u_sqw (
        .taps (div_taps),
        .sel  (st_q.ctrl.rate),
        .wave (wave)
    );

    rtc_irq_route u_route (
        .flg     (st_q.flg),
        .en      ({st_q.ctrl.a2_en, st_q.ctrl.a1_en}),
        .split   (st_q.ctrl.split),
        .wave    (wave),
        .int_a_n (int_a_n),
        .int_b_n (sqw_int_b_n)
    );

    assign ctrl_lo       = {st_q.ctrl.rate, st_q.ctrl.split, st_q.ctrl.a2_en, st_q.ctrl.a1_en};
    assign alarm_flags   = st_q.flg;
    assign osc_stop_flag = st_q.osf;
    assign osc_off       = st_q.ctrl.osc_off;
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       we,
    input logic [3:0] addr,
    input logic       wclr0,
    input logic       osc_fail,
    input logic [3:0] taps,
    input logic [1:0] flags,
    input logic       osf,
    input logic [4:0] ctrl,
    input logic       int_a_n,
    input logic       sqw_n
);
    // R10
    flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags[0]) || $rose(flags[1])) |-> $past(tick));

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 4'd8 && !wclr0 && !tick) |=> !flags[0]);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(we && addr == 4'd8)) |=> flags[0]);

    // R6
    osf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fail |=> osf);

    // R8
    sqw_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[2] |-> (sqw_n == taps[ctrl[4:3]]));

    // R7
    intb_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[2] && flags[1] && ctrl[1]) |-> !sqw_n);

    // R7
    inta_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[2] && !(flags[0] && ctrl[0])) |-> int_a_n);
endmodule

bind rtc_alarm_irq rtc_alarm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1s),
    .we       (reg_we),
    .addr     (reg_addr),
    .wclr0    (reg_wdata[0]),
    .osc_fail (osc_fail),
    .taps     (div_taps),
    .flags    (alarm_flags),
    .osf      (osc_stop_flag),
    .ctrl     (ctrl_lo),
    .int_a_n  (int_a_n),
    .sqw_n    (sqw_int_b_n)
);

// File: tb/sim_rtc_alarm_irq.sv
module sim_rtc_alarm_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [5:0] cur_wday = '0, cur_mday = '0;
    logic [3:0] taps = '0;
    logic       osc_fail = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       int_a_n, sqw_n, osf, osc_off;
    logic [1:0] flags;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_reg [0:8];
    logic [1:0] m_flg;
    logic       m_osf;

    always #2 clk = ~clk;

    rtc_alarm_irq u0 (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_mday(cur_mday), .div_taps(taps),
        .osc_fail(osc_fail), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .int_a_n(int_a_n), .sqw_int_b_n(sqw_n), .alarm_flags(flags),
        .osc_stop_flag(osf), .osc_off(osc_off)
    );

    function automatic logic exp_hit(input logic [7:0] rs, rm, rh, rd,
                                     input logic [6:0] s, mi, h,
                                     input logic [5:0] wd, md);
        logic [5:0] dref;
        dref = rd[6] ? wd : md;
        return (rs[7] || rs[6:0] == s) && (rm[7] || rm[6:0] == mi) &&
               (rh[7] || rh[6:0] == h) && (rd[7] || rd[5:0] == dref);
    endfunction

    function automatic logic exp_inta();
        logic [7:0] c;
        c = m_reg[7];
        return !((m_flg[0] && c[0]) || (!c[2] && m_flg[1] && c[1]));
    endfunction

    function automatic logic exp_sqw();
        logic [7:0] c;
        c = m_reg[7];
        return c[2] ? !(m_flg[1] && c[1]) : taps[c[4:3]];
    endfunction

    task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        cmp(req, "flags", {6'd0, flags}, {6'd0, m_flg});
        cmp(req, "osf", {7'd0, osf}, {7'd0, m_osf});
        cmp(req, "int_a_n", {7'd0, int_a_n}, {7'd0, exp_inta()});
        cmp(req, "sqw_int_b_n", {7'd0, sqw_n}, {7'd0, exp_sqw()});
        cmp(req, "osc_off", {7'd0, osc_off}, {7'd0, m_reg[7][7]});
    endtask

    // one cycle of stimulus, model update, and check after the edge
    task automatic step(input bit t, input logic [6:0] s, mi, h, input logic [5:0] wd, md,
                        input bit w, input logic [3:0] a, input logic [7:0] d,
                        input bit of, input string req);
        logic [1:0] hits;
        logic [1:0] keep;
        logic       okeep;
        @(negedge clk);
        tick = t; cur_sec = s; cur_min = mi; cur_hour = h; cur_wday = wd; cur_mday = md;
        we = w; addr = a; wdata = d; osc_fail = of; taps = 4'($urandom);
        hits[0] = exp_hit(m_reg[0], m_reg[1], m_reg[2], m_reg[3], s, mi, h, wd, md);
        hits[1] = exp_hit(8'h00, m_reg[4], m_reg[5], m_reg[6], s, mi, h, wd, md);
        keep = 2'b11; okeep = 1'b1;
        if (w && a == 4'd8) begin keep = d[1:0]; okeep = d[7]; end
        @(negedge clk);
        tick = 1'b0; we = 1'b0; osc_fail = 1'b0;
        m_flg = (m_flg & keep) | (t ? hits : 2'b00);
        m_osf = (m_osf & okeep) | of;
        if (w && a <= 4'd7) m_reg[a] = d;
        check_all(req);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
        step(1'b0, cur_sec, cur_min, cur_hour, cur_wday, cur_mday, 1'b1, a, d, 1'b0, req);
    endtask

    task automatic tk(input logic [6:0] s, mi, h, input logic [5:0] wd, md, input string req);
        step(1'b1, s, mi, h, wd, md, 1'b0, 4'd0, 8'd0, 1'b0, req);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1337));
        for (int i = 0; i <= 8; i++) m_reg[i] = 8'h00;
        m_reg[7] = 8'h18; m_flg = 2'b00; m_osf = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check_all("R1");

        // R6 oscillator-stop flag: write 1 keeps, write 0 clears, fail sets
        wr(4'd8, 8'h80, "R6");
        wr(4'd8, 8'h00, "R6");
        step(1'b0, 0, 0, 0, 0, 0, 1'b0, 0, 0, 1'b1, "R6");
        wr(4'd8, 8'h00, "R6");

        // R2 first alarm with day masked, split routing
        wr(4'd0, 8'h15, "R2"); wr(4'd1, 8'h30, "R2");
        wr(4'd2, 8'h12, "R2"); wr(4'd3, 8'h80, "R2");
        wr(4'd7, 8'h05, "R7");
        tk(7'h15, 7'h31, 7'h12, 6'd3, 6'h05, "R2");
        tk(7'h15, 7'h30, 7'h12, 6'd3, 6'h05, "R2");
        // R5 write one has no effect, write zero clears
        wr(4'd8, 8'h03, "R5");
        wr(4'd8, 8'h00, "R5");
        // R10 matching fields without a tick
        step(1'b0, 7'h15, 7'h30, 7'h12, 6'd3, 6'h05, 1'b0, 0, 0, 1'b0, "R10");
        step(1'b0, 7'h15, 7'h30, 7'h12, 6'd3, 6'h05, 1'b0, 0, 0, 1'b0, "R10");
        // R5 match and clearing write together: set wins
        step(1'b1, 7'h15, 7'h30, 7'h12, 6'd3, 6'h05, 1'b1, 4'd8, 8'h00, 1'b0, "R5");
        wr(4'd8, 8'h00, "R5");

        // R4 day/date select with date and weekday disagreeing
        wr(4'd3, 8'h05, "R4");
        tk(7'h15, 7'h30, 7'h12, 6'd3, 6'h05, "R4");
        wr(4'd8, 8'h00, "R4");
        wr(4'd3, 8'h43, "R4");
        tk(7'h15, 7'h30, 7'h12, 6'd3, 6'h09, "R4");
        wr(4'd8, 8'h00, "R4");
        wr(4'd3, 8'h45, "R4");
        tk(7'h15, 7'h30, 7'h12, 6'd3, 6'h05, "R4");

        // R3 second alarm fully masked fires only at zero seconds
        wr(4'd4, 8'h80, "R3"); wr(4'd5, 8'h80, "R3"); wr(4'd6, 8'h80, "R3");
        wr(4'd7, 8'h06, "R7");
        tk(7'h01, 7'h10, 7'h02, 6'd1, 6'h01, "R3");
        tk(7'h00, 7'h10, 7'h02, 6'd1, 6'h01, "R3");
        // R8 shared routing of second alarm onto the first pin
        wr(4'd7, 8'h02, "R8");
        wr(4'd8, 8'h00, "R8");

        // R9 every rate code
        for (int r = 0; r < 4; r++) begin
            wr(4'd7, 8'(r << 3), "R9");
            step(1'b0, 0, 0, 0, 0, 0, 1'b0, 0, 0, 1'b0, "R9");
        end
        // R11 out-of-range offsets change nothing
        wr(4'd9, 8'hFF, "R11");
        wr(4'd15, 8'h00, "R11");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 16);
            if (op < 4) begin
                wr(4'($urandom % 7), 8'($urandom), "R2");
            end else if (op == 4) begin
                wr(4'd7, 8'($urandom), "R7");
            end else if (op == 5) begin
                wr(4'd8, 8'($urandom), "R5");
            end else if (op == 6) begin
                wr(4'($urandom % 7 + 9), 8'($urandom), "R11");
            end else if (op == 7) begin
                step(1'b0, 0, 0, 0, 0, 0, 1'b0, 0, 0, 1'b1, "R6");
            end else begin
                int sel;
                logic [6:0] s, mi, h;
                logic [5:0] wd, md;
                sel = int'($urandom % 4);
                s = 7'($urandom); mi = 7'($urandom); h = 7'($urandom);
                wd = 6'($urandom); md = 6'($urandom);
                if (sel == 0) begin
                    s = m_reg[0][6:0]; mi = m_reg[1][6:0]; h = m_reg[2][6:0];
                    wd = m_reg[3][5:0]; md = m_reg[3][5:0];
                end else if (sel == 1) begin
                    s = 7'h00; mi = m_reg[4][6:0]; h = m_reg[5][6:0];
                    wd = m_reg[6][5:0]; md = m_reg[6][5:0];
                end
                if ($urandom % 8 == 0)
                    step(1'b0, s, mi, h, wd, md, 1'b0, 0, 0, 1'b0, "R10");
                else
                    tk(s, mi, h, wd, md, "R3");
            end
        end
        finish_run();
    end
endmodule